// File: doc/BRIEF.md
# Programmable Time Base Generator

This block turns a slow reference rate into a set of periodic tick strobes for a small low-power controller. The reference arrives as a one-cycle enable pulse, `refEn`, at 32.768 kHz, sampled in the system clock domain. A free-running 15-bit divider counts these pulses. Each tick output is a one-clock strobe. It fires in the clock cycle after the reference pulse that makes the tick's chosen divider bit rise. All ticks come from the same counter, so the different rates keep a fixed phase relation to each other.

Software writes an 8-bit configuration word to set two ticks. The fast tick (wake-up, counter clocking) runs at 4, 8, 16 or 32 Hz. The slow wake-up/interrupt tick runs at 2 Hz or 1 Hz. The frame tick for the display scanner follows the display duty code. Two further ticks are fixed: 2048 Hz and 128 Hz. A new selection is held back until the tick it replaces fires once more, so a change never cuts a period short or adds a strobe.

Top module: `tbase_gen`

## Requirements
- R1: While `rstN` is low all tick outputs are 0 and the divider stays at zero. After reset the fast tick runs at 4 Hz, the slow tick at 2 Hz and the frame tick at 128 Hz.
- R2: The divider advances only in cycles where `refEn` is 1. A tick is high for exactly one cycle: the cycle after the reference pulse that makes its count n (pulses since reset) reach the tick's phase. No tick fires in a cycle that does not follow a reference pulse.
- R3: `tick2k` fires when n mod 16 = 8.
- R4: `tick128` fires when n mod 256 = 128, and never in the same cycle as `tick2k`.
- R5: Configuration bits 1:0 select the fast tick, which fires when n mod 2P = P. The code values are: 00 gives 4 Hz (P = 4096), 01 gives 8 Hz (P = 2048), 10 gives 16 Hz (P = 1024), 11 gives 32 Hz (P = 512).
- R6: Configuration bit 7 selects the slow tick. With 0 it fires at 2 Hz (n mod 16384 = 8192). With 1 it fires at 1 Hz (n mod 32768 = 16384). The slow tick never fires in the same cycle as the fast tick.
- R7: Configuration bits 6:2 have no effect on any tick.
- R8: `lcdDuty` code 00 (half duty) gives a 128 Hz frame tick (n mod 256 = 128). Codes 01, 10 and 11 (third, quarter and fifth duty) give 256 Hz (n mod 128 = 64).
- R9: A new fast, slow or frame selection takes effect only after the next strobe of the rate still in use. Until then that tick keeps its old rate and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refEn | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 8 | Configuration word (bits 1:0 fast rate, bit 7 slow rate) |
| lcdDuty | input | 2 | Display duty code (00 half, 01 third, 10 quarter, 11 fifth) |
| tickFast | output | 1 | Selectable 4/8/16/32 Hz strobe |
| tickSlow | output | 1 | Selectable 2/1 Hz strobe |
| tick2k | output | 1 | 2048 Hz strobe |
| tick128 | output | 1 | 128 Hz strobe |
| tickFrame | output | 1 | Display frame strobe, 128 or 256 Hz |

## Verification
A divider count that is off by even one shows up within 16 reference pulses: every `tick2k` strobe lands one cycle early or late compared with the pulse count held by the bench. A wrong active selection is slower to surface. It only appears at the next strobe of the affected rate, which can be up to 32768 reference pulses later. For this reason the bench runs each selection through at least one full period after the change. A selection adopted too early shows as a fast strobe inside the window where the old rate still has to run.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

  // selections the control hands to the divider datapath
  typedef struct packed {
    logic [1:0] fastSel;   // 0: slowest fast tick ... 3: quickest
    logic       slowSel;   // 0: 2 Hz, 1: 1 Hz
    logic       frameSel;  // 0: 128 Hz, 1: 256 Hz
  } selCtl_t;

  // strobes the datapath returns
  typedef struct packed {
    logic fast;
    logic slow;
    logic k2;
    logic k128;
    logic frame;
  } tickStb_t;

endpackage

// File: rtl/tbg_divider.sv
module tbg_divider
  import tbg_pkg::*;
#(
  parameter int DIV_W        = 15,
  parameter int K2_BIT       = 3,
  parameter int FRAME_HI_BIT = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     refEn,
  input  selCtl_t  sel,
  output tickStb_t ticks
);

  localparam int SLOW_HI  = DIV_W - 1;
  localparam int SLOW_LO  = DIV_W - 2;
  localparam int FAST_TOP = DIV_W - 3;
  localparam int FAST_N   = 4;
  localparam int BIT_128  = FRAME_HI_BIT + 1;

  logic [DIV_W-1:0]  cnt;
  logic [FAST_N-1:0] riseFastQ;
  logic              rise2kQ, rise128Q, rise256Q, riseS2Q, riseS1Q;

  // true when the next increment makes bit k go from 0 to 1
  function automatic logic riseAt(input logic [DIV_W-1:0] c, input int k);
    logic [DIV_W-1:0] lo;
    logic [DIV_W-1:0] full;
    lo   = (DIV_W'(1) << k) - DIV_W'(1);
    full = {lo[DIV_W-2:0], 1'b1};
    return (c & full) == lo;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      rise2kQ  <= 1'b0;
      rise128Q <= 1'b0;
      rise256Q <= 1'b0;
      riseS2Q  <= 1'b0;
      riseS1Q  <= 1'b0;
    end else begin
      if (refEn) cnt <= cnt + DIV_W'(1);
      rise2kQ  <= refEn && riseAt(cnt, K2_BIT);
      rise128Q <= refEn && riseAt(cnt, BIT_128);
      rise256Q <= refEn && riseAt(cnt, FRAME_HI_BIT);
      riseS2Q  <= refEn && riseAt(cnt, SLOW_LO);
      riseS1Q  <= refEn && riseAt(cnt, SLOW_HI);
    end
  end

  // one edge detector per selectable fast rate; index 0 is the slowest
  for (genvar i = 0; i < FAST_N; i++) begin : g_fast
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) riseFastQ[i] <= 1'b0;
      else       riseFastQ[i] <= refEn && riseAt(cnt, FAST_TOP - i);
    end
  end

  always_comb begin
    ticks.fast  = riseFastQ[sel.fastSel];
    ticks.slow  = sel.slowSel  ? riseS1Q  : riseS2Q;
    ticks.k2    = rise2kQ;
    ticks.k128  = rise128Q;
    ticks.frame = sel.frameSel ? rise256Q : rise128Q;
  end

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    ticks.k2 |=> !ticks.k2);

  assert_fast_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    ticks.fast |=> !ticks.fast);

  assert_needs_ref_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ticks.fast || ticks.slow || ticks.k2 || ticks.k128 || ticks.frame) |-> $past(refEn));

  assert_phase_128_R4: assert property (@(posedge clk) disable iff (!rstN)
    ticks.k128 |-> !ticks.k2);

  assert_phase_slow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ticks.slow |-> !ticks.fast);

endmodule

// File: rtl/tbg_ctrl.sv
module tbg_ctrl
  import tbg_pkg::*;
#(
  parameter int CFG_W        = 8,
  parameter int FAST_SEL_LSB = 0,
  parameter int SLOW_SEL_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [1:0]       lcdDuty,
  input  tickStb_t         ticks,
  output selCtl_t          sel
);

  localparam logic [CFG_W-1:0] USED_MASK =
    (CFG_W'(3) << FAST_SEL_LSB) | (CFG_W'(1) << SLOW_SEL_BIT);

  logic [1:0] fastPend;
  logic       slowPend;
  logic       frameWant;
  logic       unusedCfgBits;

  assign unusedCfgBits = ^(cfgWrData & ~USED_MASK);
  assign frameWant     = (lcdDuty != 2'b00);

  // written value waits here until the old rate strobes once more
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastPend <= 2'b00;
      slowPend <= 1'b0;
    end else if (cfgWrEn) begin
      fastPend <= cfgWrData[FAST_SEL_LSB +: 2];
      slowPend <= cfgWrData[SLOW_SEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel <= '0;
    end else begin
      if (ticks.fast)  sel.fastSel  <= fastPend;
      if (ticks.slow)  sel.slowSel  <= slowPend;
      if (ticks.frame) sel.frameSel <= frameWant;
    end
  end

  assert_fast_switch_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sel.fastSel) |-> $past(ticks.fast));

  assert_slow_switch_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sel.slowSel) |-> $past(ticks.slow));

  assert_frame_switch_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sel.frameSel) |-> $past(ticks.frame));

endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
  import tbg_pkg::*;
#(
  parameter int DIV_W        = 15,
  parameter int CFG_W        = 8,
  parameter int FAST_SEL_LSB = 0,
  parameter int SLOW_SEL_BIT = 7,
  parameter int K2_BIT       = 3,
  parameter int FRAME_HI_BIT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEn,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [1:0]       lcdDuty,
  output logic             tickFast,
  output logic             tickSlow,
  output logic             tick2k,
  output logic             tick128,
  output logic             tickFrame
);

  selCtl_t  selBus;
  tickStb_t tickBus;

  tbg_ctrl #(
    .CFG_W(CFG_W), .FAST_SEL_LSB(FAST_SEL_LSB), .SLOW_SEL_BIT(SLOW_SEL_BIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .lcdDuty(lcdDuty), .ticks(tickBus), .sel(selBus)
  );

  tbg_divider #(
    .DIV_W(DIV_W), .K2_BIT(K2_BIT), .FRAME_HI_BIT(FRAME_HI_BIT)
  ) div_i (
    .clk(clk), .rstN(rstN), .refEn(refEn), .sel(selBus), .ticks(tickBus)
  );

  assign tickFast  = tickBus.fast;
  assign tickSlow  = tickBus.slow;
  assign tick2k    = tickBus.k2;
  assign tick128   = tickBus.k128;
  assign tickFrame = tickBus.frame;

endmodule

// File: tb/tbase_gen_tb_top.sv
`timescale 1ns/1ps
module tbase_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refEn = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [1:0] lcdDuty = 2'b00;
  logic       tickFast, tickSlow, tick2k, tick128, tickFrame;

  always #10 clk = ~clk;

  tbase_gen dut_i (
    .clk(clk), .rstN(rstN), .refEn(refEn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .lcdDuty(lcdDuty), .tickFast(tickFast),
    .tickSlow(tickSlow), .tick2k(tick2k), .tick128(tick128),
    .tickFrame(tickFrame)
  );

  int  checks = 0;
  int  errors = 0;
  int  nRef;
  int  actFast, pendFast, actSlow, pendSlow, actFrame;
  bit  prevF, prevS, prevFr;
  int  misCnt;
  string misText;
  int  obsFast, obsSlow, obs2k, obsFrame;
  int  expFast, expSlow, exp2k, expFrame;

  function automatic bit rise(int n, int k);
    return (n % (1 << (k + 1))) == (1 << k);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearWin();
    misCnt = 0; misText = "";
    obsFast = 0; obsSlow = 0; obs2k = 0; obsFrame = 0;
    expFast = 0; expSlow = 0; exp2k = 0; expFrame = 0;
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit r, bit w, logic [7:0] d);
    bit eF, eS, e2, e128, eFr;
    int nf, ns, nfr;
    refEn = r; cfgWrEn = w; cfgWrData = d;
    @(posedge clk);
    nf  = prevF  ? pendFast : actFast;
    ns  = prevS  ? pendSlow : actSlow;
    nfr = prevFr ? int'(lcdDuty != 2'b00) : actFrame;
    actFast = nf; actSlow = ns; actFrame = nfr;
    if (w) begin pendFast = int'(d[1:0]); pendSlow = int'(d[7]); end
    if (r) nRef++;
    eF   = r && rise(nRef, 12 - actFast);
    eS   = r && rise(nRef, actSlow ? 14 : 13);
    e2   = r && rise(nRef, 3);
    e128 = r && rise(nRef, 7);
    eFr  = r && rise(nRef, actFrame ? 6 : 7);
    @(negedge clk);
    if ({tickFast, tickSlow, tick2k, tick128, tickFrame} != {eF, eS, e2, e128, eFr}) begin
      if (misCnt == 0)
        misText = $sformatf("n=%0d got=%05b exp=%05b", nRef,
          {tickFast, tickSlow, tick2k, tick128, tickFrame}, {eF, eS, e2, e128, eFr});
      misCnt++;
    end
    obsFast += int'(tickFast); obsSlow += int'(tickSlow);
    obs2k += int'(tick2k); obsFrame += int'(tickFrame);
    expFast += int'(eF); expSlow += int'(eS);
    exp2k += int'(e2); expFrame += int'(eFr);
    prevF = eF; prevS = eS; prevFr = eFr;
    refEn = 1'b0; cfgWrEn = 1'b0;
  endtask

  task automatic run(int count);
    for (int i = 0; i < count; i++) step(1'b1, 1'b0, 8'h00);
  endtask

  task automatic winCheck(string req);
    if (misCnt != 0) $display("  first mismatch %s", misText);
    chk(misCnt == 0, req, "mismatching cycles", misCnt, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    for (int i = 0; i < 40; i++) begin
      refEn = 1'b1;
      @(negedge clk);
    end
    chk({tickFast, tickSlow, tick2k, tick128, tickFrame} == 5'b0, "R1", "ticks in reset",
        int'({tickFast, tickSlow, tick2k, tick128, tickFrame}), 0);
    refEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    nRef = 0; actFast = 0; pendFast = 0; actSlow = 0; pendSlow = 0; actFrame = 0;
    prevF = 0; prevS = 0; prevFr = 0;
    chk({tickFast, tickSlow, tick2k, tick128, tickFrame} == 5'b0, "R1", "ticks after release",
        int'({tickFast, tickSlow, tick2k, tick128, tickFrame}), 0);
    // first 2 kHz strobe must follow pulse 8 exactly: divider started at zero
    clearWin();
    run(8);
    chk(obs2k == 1 && tick2k == 1'b1, "R1", "2k strobe at pulse 8", obs2k, 1);
  endtask

  task automatic testDefault();
    clearWin();
    run(17000);
    winCheck("R1");
    chk(obsFast == 2, "R1", "4 Hz strobes in 17000 pulses", obsFast, 2);
    chk(obsSlow == 1, "R1", "2 Hz strobes in 17000 pulses", obsSlow, 1);
    chk(obs2k == exp2k, "R3", "2 kHz strobe count", obs2k, exp2k);
    chk(obsFrame == expFrame, "R4", "128 Hz strobe count", obsFrame, expFrame);
  endtask

  task automatic testGaps();
    clearWin();
    for (int i = 0; i < 900; i++) step(i % 3 == 0, 1'b0, 8'h00);
    winCheck("R2");
    chk(obs2k == exp2k, "R2", "2 kHz strobes with sparse reference", obs2k, exp2k);
  endtask

  task automatic testIgnored();
    clearWin();
    step(1'b1, 1'b1, 8'h7C);
    run(9000);
    winCheck("R7");
    chk(obsFast == expFast, "R7", "fast strobes after writing bits 6:2", obsFast, expFast);
  endtask

  task automatic testFrame();
    for (int c = 0; c < 4; c++) begin
      lcdDuty = 2'(c);
      clearWin();
      run(600);
      winCheck("R8");
      chk(obsFrame == expFrame, "R8", $sformatf("frame strobes duty code %0d", c), obsFrame, expFrame);
    end
    lcdDuty = 2'b00;
    run(300);
  endtask

  task automatic testFastSel();
    clearWin();
    step(1'b1, 1'b1, 8'h01); run(8000);
    step(1'b1, 1'b1, 8'h02); run(5000);
    step(1'b1, 1'b1, 8'h03); run(3000);
    step(1'b1, 1'b1, 8'h00); run(12000);
    winCheck("R5");
    chk(obsFast == expFast, "R5", "fast strobes across all codes", obsFast, expFast);
  endtask

  task automatic testSwitch();
    int guard = 0;
    while (!tickFast && guard < 9000) begin step(1'b1, 1'b0, 8'h00); guard++; end
    chk(tickFast == 1'b1, "R9", "4 Hz strobe found", int'(tickFast), 1);
    clearWin();
    step(1'b1, 1'b1, 8'h03);
    run(2000);
    chk(obsFast == 0, "R9", "no 32 Hz strobe before old period ends", obsFast, 0);
    run(7000);
    winCheck("R9");
    chk(obsFast == expFast, "R9", "strobes after switch", obsFast, expFast);
  endtask

  task automatic testSlow();
    clearWin();
    step(1'b1, 1'b1, 8'h83);
    run(50000);
    winCheck("R6");
    chk(obsSlow == expSlow, "R6", "slow strobes at 1 Hz", obsSlow, expSlow);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testDefault();
    testGaps();
    testIgnored();
    testFrame();
    testFastSel();
    testSwitch();
    testSlow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule